// File: doc/BRIEF.md
# Monochrome Bitmap Raster Generator

This block produces a complete monochrome raster for a bitmapped display. It runs on its own once released from reset: two counters walk through every clock of a line and every line of a frame, decode the blanking and sync intervals, and ask a memory-side DMA engine for each 16-pixel word it will show. Each word is two bits wide on the output side per clock: one pixel is presented while the clock is high and the next while it is low, so 576 visible pixels fit into 288 visible clocks of a 381-clock line at the default settings.

Words arrive over a request/acknowledge handshake into a staging register. One slot (8 clocks) before a word is shown, the generator raises a request; the memory side answers with an acknowledge and the data, which is parked in the staging register and moved into the output shifter on the last clock before its slot starts. The first word of each visible line is requested at the tail of the previous line. Once per frame, on the first clock of the final line, a one-clock pulse tells the DMA side to rewind its address counter before the next frame's first fetch. The single pixel bit drives both bits of every colour output, so the picture is black or white.

Top module: `bitmap_vga`

## Requirements
- R1: During and directly after a synchronous active-low reset, hsync_n and vsync_n are 1, dma_req and frame_restart are 0 and all colour outputs are 0; the line and frame counters restart at column 0, line 0.
- R2: The column advances once per clock and wraps after H_TOTAL clocks; hsync_n is 0 exactly for columns HS_ON through HS_OFF-1 and 1 elsewhere.
- R3: The line number advances when the column wraps and itself wraps after V_TOTAL lines; vsync_n is 0 exactly for lines VS_ON through VS_OFF-1.
- R4: All colour outputs are 0 whenever the column is at least H_VIS or the line is at least V_VIS.
- R5: dma_req is set in the clock after a fetch point; fetch points are columns 0, 8, ... H_VIS-16 of a visible line (line below V_VIS) plus column H_TOTAL-8 of any line followed by a visible line (line V_VIS-2 and below, or line V_TOTAL-1).
- R6: Once set, dma_req stays 1 until a clock in which dma_ack is 1, and is 0 in the next clock unless that clock was also a fetch point.
- R7: dma_word sampled with dma_ack while dma_req is 1 is shown in the next 8-clock slot: in slot clock j (0..7) the pixel is word bit 15-2j while the clock is high and bit 14-2j while it is low.
- R8: dma_ack while dma_req is 0 is ignored: the word shown is the one taken under a pending request.
- R9: If no acknowledge arrives before a slot starts, sync and blanking timing are unchanged and the slot shows the previously staged word again.
- R10: red, green and blue each carry the current pixel on both of their bits.
- R11: frame_restart is 1 for exactly one clock per frame, at column 0 of line V_TOTAL-1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-pair clock; its high and low phases each carry one pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_req | output | 1 | Word fetch request, held until acknowledged |
| dma_ack | input | 1 | Acknowledge; qualifies dma_word |
| dma_word | input | 16 | Pixel word, bit 15 shown first |
| frame_restart | output | 1 | One-clock pulse to rewind the DMA address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 2 | Red intensity, both bits equal to the pixel |
| green | output | 2 | Green intensity, both bits equal to the pixel |
| blue | output | 2 | Blue intensity, both bits equal to the pixel |

## Verification
The embedded properties watch, cycle by cycle, that sync ends at the right column, that the line count only moves on a column wrap, that a request is held until acknowledged and then cleared, that a stray acknowledge leaves the staging register alone, that a load copies the staged word and that the frame pulse is a single clock outside the picture. Only the bench's scenarios can show the pixel stream itself: which word lands in which slot, the bit order within the high and low phases, the reuse of a stale word after a missed acknowledge, and the placement of fetches at the line tail; the bench runs these with short timing parameters so several full frames fit in the run.

// File: rtl/vga_pkg.sv
`timescale 1ns/1ps
// Shared types for the bitmap raster generator.
// Assumes: one control bundle travels from the timer to the fetch and shift stages.
package vga_pkg;
    typedef struct packed {
        logic strobe;   // fetch point: request the next word
        logic load;     // last clock before a slot: move staged word to shifter
        logic vis;      // column and line both inside the picture
        logic hsync_n;
        logic vsync_n;
        logic restart;  // rewind pulse for the DMA address
    } raster_ctl_t;
endpackage

// File: rtl/raster_timer.sv
`timescale 1ns/1ps
// Column/line counters and all timing decodes for the raster.
// Assumes: SLOT is a power of two and H_VIS is a multiple of SLOT;
// every decode is taken from the counter registers of the current clock.
module raster_timer
    import vga_pkg::*;
#(
    parameter int unsigned H_VIS   = 288,
    parameter int unsigned HS_ON   = 308,
    parameter int unsigned HS_OFF  = 353,
    parameter int unsigned H_TOTAL = 381,
    parameter int unsigned V_VIS   = 455,
    parameter int unsigned VS_ON   = 486,
    parameter int unsigned VS_OFF  = 488,
    parameter int unsigned V_TOTAL = 528,
    parameter int unsigned SLOT    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    output raster_ctl_t ctl
);
    localparam int unsigned HW = $clog2(H_TOTAL);
    localparam int unsigned VW = $clog2(V_TOTAL);
    localparam int unsigned SW = $clog2(SLOT);
    localparam logic [HW-1:0] H_LAST    = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_VIS_C   = HW'(H_VIS);
    localparam logic [HW-1:0] H_FET_END = HW'(H_VIS - SLOT);
    localparam logic [HW-1:0] H_LD_END  = HW'(H_VIS - 1);
    localparam logic [HW-1:0] H_PRE     = HW'(H_TOTAL - SLOT);
    localparam logic [HW-1:0] HS_ON_C   = HW'(HS_ON);
    localparam logic [HW-1:0] HS_OFF_C  = HW'(HS_OFF);
    localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_VIS_C   = VW'(V_VIS);
    localparam logic [VW-1:0] V_PRE_END = VW'(V_VIS - 1);
    localparam logic [VW-1:0] VS_ON_C   = VW'(VS_ON);
    localparam logic [VW-1:0] VS_OFF_C  = VW'(VS_OFF);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT - 1);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          line_vis;
    logic          next_vis;
    logic [SW-1:0] slot_pos;

    // Purpose: advance the column every clock and the line on each column wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt == H_LAST) begin
            hcnt <= '0;
            vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Purpose: decode fetch, load, visibility, sync and rewind from the counters.
    always_comb begin
        line_vis    = (vcnt < V_VIS_C);
        next_vis    = (vcnt == V_LAST) || (vcnt < V_PRE_END);
        slot_pos    = hcnt[SW-1:0];
        ctl.strobe  = (line_vis && (hcnt < H_FET_END) && (slot_pos == '0))
                    || ((hcnt == H_PRE) && next_vis);
        ctl.load    = (line_vis && (hcnt < H_LD_END) && (slot_pos == SLOT_LAST))
                    || ((hcnt == H_LAST) && next_vis);
        ctl.vis     = line_vis && (hcnt < H_VIS_C);
        ctl.hsync_n = !((hcnt >= HS_ON_C) && (hcnt < HS_OFF_C));
        ctl.vsync_n = !((vcnt >= VS_ON_C) && (vcnt < VS_OFF_C));
        ctl.restart = (hcnt == '0) && (vcnt == V_LAST);
    end

    // R2: horizontal sync always ends leaving the last sync column.
    assert_hsync_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.hsync_n) |-> ($past(hcnt) == HW'(HS_OFF - 1)));
    // R3: the line number only moves on a column wrap.
    assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcnt) |-> ($past(hcnt) == H_LAST));
    // R11: the rewind pulse never lasts two clocks.
    assert_restart_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.restart |=> !ctl.restart);
endmodule

// File: rtl/word_fetch.sv
`timescale 1ns/1ps
// Request/acknowledge handshake and staging register for pixel words.
// Assumes: the memory side answers a held request with one acknowledge;
// an acknowledge without a pending request carries no meaning.
module word_fetch #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              ack,
    input  logic [WORD_W-1:0] word_in,
    output logic              req,
    output logic [WORD_W-1:0] stage
);
    // Purpose: hold the request until acknowledged and capture the answered word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req   <= 1'b0;
            stage <= '0;
        end else begin
            if (ack && req) stage <= word_in;
            req <= strobe || (req && !ack);
        end
    end

    // R6: an unanswered request is held.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);
    // R6: an answered request clears unless a new fetch point coincides.
    assert_req_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !strobe) |=> !req);
    // R8: a stray acknowledge leaves the staged word alone.
    assert_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> $stable(stage));
endmodule

// File: rtl/pixel_shifter.sv
`timescale 1ns/1ps
// Parallel-load shifter emitting two pixels per clock, one per clock phase.
// Assumes: the clock duty cycle is near half; the high phase shows the more
// significant bit of the current pair.
module pixel_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              vis,
    input  logic [WORD_W-1:0] stage,
    output logic              pixel
);
    logic [WORD_W-1:0] sh;

    // Purpose: load a staged word before its slot, else move on by one pair.
    always_ff @(posedge clk) begin
        if (!rst_n)    sh <= '0;
        else if (load) sh <= stage;
        else           sh <= {sh[WORD_W-3:0], 2'b00};
    end

    // Purpose: pick the pair bit for the current clock phase, blanked outside the picture.
    always_comb begin
        pixel = vis && (clk ? sh[WORD_W-1] : sh[WORD_W-2]);
    end

    // R7: a load copies the staged word into the shifter.
    assert_load_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh == $past(stage)));
endmodule

// File: rtl/bitmap_vga.sv
`timescale 1ns/1ps
// Top of the monochrome raster generator: timer, word fetch, pixel shifter
// and colour fan-out. Assumes a single clock domain and a DMA partner that
// answers each request before the slot that needs the word.
module bitmap_vga
    import vga_pkg::*;
#(
    parameter int unsigned H_VIS   = 288,
    parameter int unsigned HS_ON   = 308,
    parameter int unsigned HS_OFF  = 353,
    parameter int unsigned H_TOTAL = 381,
    parameter int unsigned V_VIS   = 455,
    parameter int unsigned VS_ON   = 486,
    parameter int unsigned VS_OFF  = 488,
    parameter int unsigned V_TOTAL = 528,
    parameter int unsigned WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              dma_req,
    input  logic              dma_ack,
    input  logic [WORD_W-1:0] dma_word,
    output logic              frame_restart,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic [1:0]        red,
    output logic [1:0]        green,
    output logic [1:0]        blue
);
    localparam int unsigned SLOT   = WORD_W / 2;
    localparam int unsigned COLOUR = 6;

    raster_ctl_t       ctl;
    logic [WORD_W-1:0] stage;
    logic              pixel;
    logic [COLOUR-1:0] rgb;

    raster_timer #(
        .H_VIS(H_VIS), .HS_ON(HS_ON), .HS_OFF(HS_OFF), .H_TOTAL(H_TOTAL),
        .V_VIS(V_VIS), .VS_ON(VS_ON), .VS_OFF(VS_OFF), .V_TOTAL(V_TOTAL),
        .SLOT(SLOT)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .ctl(ctl)
    );

    word_fetch #(.WORD_W(WORD_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .strobe(ctl.strobe), .ack(dma_ack),
        .word_in(dma_word), .req(dma_req), .stage(stage)
    );

    pixel_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(ctl.load), .vis(ctl.vis),
        .stage(stage), .pixel(pixel)
    );

    // Purpose: drive every colour bit from the single pixel.
    for (genvar g = 0; g < COLOUR; g++) begin : g_fan
        assign rgb[g] = pixel;
    end

    assign red           = rgb[1:0];
    assign green         = rgb[3:2];
    assign blue          = rgb[5:4];
    assign hsync_n       = ctl.hsync_n;
    assign vsync_n       = ctl.vsync_n;
    assign frame_restart = ctl.restart;

    // R11: the rewind pulse falls outside the picture.
    assert_restart_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_restart |-> !ctl.vis);
endmodule

// File: tb/sim_bitmap_vga.sv
`timescale 1ns/1ps
// Bench for bitmap_vga with short timing parameters; a reference model of
// counters, request, staging and slot word predicts every output per phase.
module sim_bitmap_vga;
    localparam int H_VIS = 32, HS_ON = 36, HS_OFF = 40, H_TOTAL = 45;
    localparam int V_VIS = 4, VS_ON = 6, VS_OFF = 8, V_TOTAL = 10;

    logic        clk = 1'b0;
    logic        rst_drv = 1'b0;
    logic        ack_drv = 1'b0;
    logic [15:0] ack_word = 16'h0;
    logic        dma_req, frame_restart, hsync_n, vsync_n;
    logic [1:0]  red, green, blue;

    bitmap_vga #(
        .H_VIS(H_VIS), .HS_ON(HS_ON), .HS_OFF(HS_OFF), .H_TOTAL(H_TOTAL),
        .V_VIS(V_VIS), .VS_ON(VS_ON), .VS_OFF(VS_OFF), .V_TOTAL(V_TOTAL),
        .WORD_W(16)
    ) u0 (
        .clk(clk), .rst_n(rst_drv), .dma_req(dma_req), .dma_ack(ack_drv),
        .dma_word(ack_word), .frame_restart(frame_restart), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .red(red), .green(green), .blue(blue)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0;
    int mh = 0, mv = 0, rcnt = -1, mode = 0;
    bit mreq = 0, fresh = 0, mstale = 0, spur_pend = 0, slot_spur = 0, last_s = 0, alt = 0;
    logic [15:0] mstage = 0, mshift = 0;

    function automatic bit f_vis(int h, int v);
        return (h < H_VIS) && (v < V_VIS);
    endfunction
    function automatic bit f_fetch(int h, int v);
        bit nv = (v == V_TOTAL - 1) || (v < V_VIS - 1);
        return ((v < V_VIS) && (h < H_VIS - 8) && (h % 8 == 0)) || ((h == H_TOTAL - 8) && nv);
    endfunction
    function automatic bit f_load(int h, int v);
        bit nv = (v == V_TOTAL - 1) || (v < V_VIS - 1);
        return ((v < V_VIS) && (h < H_VIS - 1) && (h % 8 == 7)) || ((h == H_TOTAL - 1) && nv);
    endfunction
    function automatic bit f_pix(int h, int v, logic [15:0] w, bit hi);
        int j = h % 8;
        if (!f_vis(h, v)) return 1'b0;
        return hi ? w[15 - 2*j] : w[14 - 2*j];
    endfunction
    function automatic string f_pix_tag(int h, int v);
        if (!f_vis(h, v)) return "R4";
        if (mstale) return "R9";
        if (slot_spur) return "R8";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s at col %0d line %0d: actual=%0d expected=%0d", tag, mh, mv, act, exp);
        end
    endtask

    task automatic check_colour(input bit hi);
        bit e = f_pix(mh, mv, mshift, hi);
        logic [5:0] act = {red, green, blue};
        string t = rst_drv ? f_pix_tag(mh, mv) : "R1";
        check(act[0] == e, t, int'(act[0]), int'(e));
        check(act == {6{act[0]}}, "R10", int'(act), int'({6{act[0]}}));
    endtask

    // One clock: update model with the inputs seen at the edge, then check both phases.
    task automatic step();
        @(posedge clk);
        if (!rst_drv) begin
            mh = 0; mv = 0; mreq = 0; mstage = 0; mshift = 0;
            fresh = 0; mstale = 0; spur_pend = 0; slot_spur = 0; last_s = 0; rcnt = -1;
        end else begin
            last_s = f_fetch(mh, mv);
            if (f_load(mh, mv)) begin
                mshift = mstage; mstale = !fresh; fresh = 0;
                slot_spur = spur_pend; spur_pend = 0;
            end
            if (ack_drv && mreq) begin mstage = ack_word; fresh = 1; end
            mreq = last_s || (mreq && !ack_drv);
            if (mh == H_TOTAL - 1) begin
                mh = 0; mv = (mv == V_TOTAL - 1) ? 0 : mv + 1;
            end else mh = mh + 1;
        end
        #1;
        if (!rst_drv) begin
            check(hsync_n == 1'b1, "R1", int'(hsync_n), 1);
            check(vsync_n == 1'b1, "R1", int'(vsync_n), 1);
            check(dma_req == 1'b0, "R1", int'(dma_req), 0);
            check(frame_restart == 1'b0, "R1", int'(frame_restart), 0);
        end else begin
            bit eh = !((mh >= HS_ON) && (mh < HS_OFF));
            bit ev = !((mv >= VS_ON) && (mv < VS_OFF));
            bit er = (mh == 0) && (mv == V_TOTAL - 1);
            check(hsync_n == eh, (mode == 2) ? "R9" : "R2", int'(hsync_n), int'(eh));
            check(vsync_n == ev, "R3", int'(vsync_n), int'(ev));
            check(frame_restart == er, "R11", int'(frame_restart), int'(er));
            check(dma_req == mreq, last_s ? "R5" : "R6", int'(dma_req), int'(mreq));
        end
        check_colour(1'b1);
        #2.5;
        check_colour(1'b0);
        ack_drv = 1'b0;
        if (rst_drv) begin
            if (dma_req && rcnt < 0) begin
                case (mode)
                    0: begin rcnt = alt ? 4 : 0; alt = !alt; end
                    1: rcnt = int'($urandom % 5);
                    default: rcnt = ($urandom % 4 == 0) ? 9 : int'($urandom % 5);
                endcase
            end
            if (rcnt == 0) begin
                ack_drv = 1'b1; ack_word = 16'($urandom); rcnt = -1;
            end else if (rcnt > 0) begin
                rcnt--;
            end else if (!dma_req && mode != 0 && ($urandom % 6 == 0)) begin
                ack_drv = 1'b1; ack_word = 16'($urandom); spur_pend = 1;
            end
        end
    endtask

    bit timeout = 0;

    initial begin
        void'($urandom(32'd20240611));
        fork
            begin
                repeat (4) step();                 // R1 reset state
                rst_drv = 1'b1;
                mode = 0; repeat (900) step();     // directed 0 and 4 clock answers
                mode = 1; repeat (900) step();     // random answers plus stray acks (R8)
                mode = 2; repeat (900) step();     // missed answers (R9)
                rst_drv = 1'b0; repeat (3) step(); // mid-run reset (R1)
                rst_drv = 1'b1;
                mode = 1; repeat (500) step();
            end
            begin
                #100000;
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual=expired expected=completed");
        end
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule